// File: doc/BRIEF.md
# Indexed Palette DAC Register Interface

This block holds a 256-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue value. A host loads the table through a 16-byte window of 32-bit registers. Every write to that window must use all four byte lanes.

To load colours, the host first writes an entry number to the index register. It then writes one colour component at a time to the data register. An internal sequencer steps through red, green and blue in that order. After the blue component the index moves on to the next entry, so a whole table can be streamed after a single index write.

The pixel pipeline reads the table through a combinational port: it presents an index and gets back the packed colour in the same cycle. Each committed component write also produces a one-cycle change pulse that carries the affected index, so downstream logic can schedule a redraw.

Top module: `pal_dac_top`

## Requirements
- R1: After reset, entries 0 to 254 read as black (0x000000) and entry 255 reads as white (0xFFFFFF). The read port packs each entry as {red[23:16], green[15:8], blue[7:0]}.
- R2: A write to byte offset 0 with all byte enables set loads the index from data bits 31:24 and returns the sequencer to the red step. This also applies partway through a colour.
- R3: Writes to byte offset 4 with all byte enables set take the value from data bits 31:24. They store it into the red, then green, then blue field of the entry at the current index.
- R4: The write that stores blue increments the index modulo 256 and returns the sequencer to red, so 255 is followed by 0.
- R5: Reset sets the index to 0 and the sequencer to red, so the first component write after reset lands in the red field of entry 0.
- R6: Writes to byte offsets 8 and 12, and to any offset that is not a multiple of 4, change neither the table, the index nor the sequencer, and raise no change pulse.
- R7: Writes with any byte enable low change neither the table, the index nor the sequencer, and raise no change pulse.
- R8: The host read data output is always zero.
- R9: The palette read port is combinational. A read of an entry in the same cycle as a component write to that entry returns the value held before the write.
- R10: `chg_valid` is high for exactly the one cycle after the clock edge that commits a component write, with `chg_index` equal to the written entry. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | 4 | Byte offset within the register window |
| wr_be | input | 4 | Byte enables; all four must be set |
| wr_data | input | 32 | Write data; the value is taken from bits 31:24 |
| rd_data | output | 32 | Host read data, always zero |
| pix_index | input | 8 | Palette entry read by the pixel pipeline |
| pix_rgb | output | 24 | Colour of the entry at `pix_index` |
| chg_valid | output | 1 | One-cycle pulse after each committed component write |
| chg_index | output | 8 | Entry written, valid while `chg_valid` is high |

## Verification
A host component write and a pixel-side read can target the same entry in the same cycle. The bench provokes this by pointing `pix_index` at the entry about to be written, then driving the write. It samples `pix_rgb` just before the committing edge, where the old colour is expected, and again just after that edge, where the new colour is expected.

An index reload can also arrive in the middle of a colour. The bench checks that the next component lands in the red field of the new entry, and that the partly written old entry keeps exactly what it had received.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int BE_W     = BUS_W / 8;
    localparam int COMP_W   = 8;
    localparam int IDX_W    = 8;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int RGB_W    = 3 * COMP_W;

    localparam logic [ADDR_W-1:0] OFS_INDEX = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_COMP  = 4'h4;

    typedef enum logic [1:0] {
        STEP_R = 2'd0,
        STEP_G = 2'd1,
        STEP_B = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INDEX = 2'd1,
        OP_COMP  = 2'd2
    } op_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    localparam rgb_t RGB_BLACK = '{r: '0, g: '0, b: '0};
    localparam rgb_t RGB_WHITE = '{r: '1, g: '1, b: '1};

    // Only full-word accesses to the two live offsets do anything.
    function automatic op_e decode_op(input logic            valid,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic [BE_W-1:0]   be);
        op_e op;
        op = OP_NONE;
        if (valid && (be == {BE_W{1'b1}})) begin
            if (addr == OFS_INDEX)     op = OP_INDEX;
            else if (addr == OFS_COMP) op = OP_COMP;
        end
        return op;
    endfunction

    function automatic step_e next_step(input step_e s);
        step_e n;
        case (s)
            STEP_R:  n = STEP_G;
            STEP_G:  n = STEP_B;
            default: n = STEP_R;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pal_regif.sv
module pal_regif
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [COMP_W-1:0] wr_byte,
    output logic              cw_en,
    output logic [IDX_W-1:0]  cw_idx,
    output step_e             cw_step,
    output logic [COMP_W-1:0] cw_val
);

    op_e              op;
    logic [IDX_W-1:0] idx_q;
    step_e            step_q;

    assign op = decode_op(wr_valid, wr_addr, wr_be);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            step_q <= STEP_R;
        end else begin
            case (op)
                OP_INDEX: begin
                    idx_q  <= wr_byte;
                    step_q <= STEP_R;
                end
                OP_COMP: begin
                    if (step_q == STEP_B) begin
                        idx_q <= idx_q + 1'b1;
                    end
                    step_q <= next_step(step_q);
                end
                default: ;
            endcase
        end
    end

    assign cw_en   = (op == OP_COMP);
    assign cw_idx  = idx_q;
    assign cw_step = step_q;
    assign cw_val  = wr_byte;

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INDEX) |=> (idx_q == $past(wr_byte)) && (step_q == STEP_R)); // R2

    AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_COMP && step_q == STEP_B) |=>
            (idx_q == $past(idx_q) + 1'b1) && (step_q == STEP_R)); // R4

    AST_IGNORED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && op == OP_NONE) |=> $stable(idx_q) && $stable(step_q)); // R6

    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_R) || (step_q == STEP_G) || (step_q == STEP_B)); // R3

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  step_e             cw_step,
    input  logic [COMP_W-1:0] cw_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output rgb_t              rd_rgb
);

    rgb_t table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                table_q[i] <= (i == DEPTH - 1) ? RGB_WHITE : RGB_BLACK;
            end
        end else if (cw_en) begin
            case (cw_step)
                STEP_R:  table_q[cw_idx].r <= cw_val;
                STEP_G:  table_q[cw_idx].g <= cw_val;
                default: table_q[cw_idx].b <= cw_val;
            endcase
        end
    end

    // Combinational read: a same-cycle write is seen only after the edge.
    assign rd_rgb = table_q[rd_idx];

    AST_RED_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cw_en && cw_step == STEP_R) |=> table_q[$past(cw_idx)].r == $past(cw_val)); // R3

    AST_BLUE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cw_en && cw_step == STEP_B) |=> table_q[$past(cw_idx)].b == $past(cw_val)); // R3

    AST_QUIET_TABLE: assert property (@(posedge clk) disable iff (rst)
        !cw_en |=> table_q[$past(rd_idx)] == $past(rd_rgb)); // R7

endmodule

// File: rtl/pal_dac_top.sv
module pal_dac_top
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [IDX_W-1:0]  pix_index,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic              chg_valid,
    output logic [IDX_W-1:0]  chg_index
);

    localparam int LOW_W = BUS_W - COMP_W;

    logic              cw_en;
    logic [IDX_W-1:0]  cw_idx;
    step_e             cw_step;
    logic [COMP_W-1:0] cw_val;
    rgb_t              rd_rgb;
    logic              unused_low;

    assign unused_low = ^wr_data[LOW_W-1:0];

    pal_regif u_regif (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_be    (wr_be),
        .wr_byte  (wr_data[BUS_W-1 -: COMP_W]),
        .cw_en    (cw_en),
        .cw_idx   (cw_idx),
        .cw_step  (cw_step),
        .cw_val   (cw_val)
    );

    pal_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cw_en   (cw_en),
        .cw_idx  (cw_idx),
        .cw_step (cw_step),
        .cw_val  (cw_val),
        .rd_idx  (pix_index),
        .rd_rgb  (rd_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chg_valid <= 1'b0;
            chg_index <= '0;
        end else begin
            chg_valid <= cw_en;
            chg_index <= cw_idx;
        end
    end

    assign pix_rgb = rd_rgb;
    assign rd_data = '0;

    AST_CHG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        cw_en |=> chg_valid && (chg_index == $past(cw_idx))); // R10

    AST_CHG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cw_en |=> !chg_valid); // R10

endmodule

// File: tb/test_pal_dac_top.sv
module test_pal_dac_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_rgb;
    logic        chg_valid;
    logic [7:0]  chg_index;

    int checks = 0;
    int fails = 0;
    logic [23:0] exp_mem [256];
    int e_idx;
    int e_step;

    always #4 clk = ~clk;

    pal_dac_top i_pal_dac_top (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pix_index (pix_index),
        .pix_rgb   (pix_rgb),
        .chg_valid (chg_valid),
        .chg_index (chg_index)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 256; i++) begin
            pix_index = i[7:0];
            #1;
            chk(pix_rgb == exp_mem[i], req, {8'h0, pix_rgb}, {8'h0, exp_mem[i]});
        end
    endtask

    // Bench model of the sequencer, taken from R2..R7.
    task automatic model_write(input logic [3:0] a, input logic [3:0] be,
                               input logic [7:0] v, output bit is_comp, output int ci);
        is_comp = 0;
        ci = e_idx;
        if (be == 4'hF && a == 4'h0) begin
            e_idx = v;
            e_step = 0;
        end else if (be == 4'hF && a == 4'h4) begin
            is_comp = 1;
            case (e_step)
                0: exp_mem[ci][23:16] = v;
                1: exp_mem[ci][15:8]  = v;
                default: exp_mem[ci][7:0] = v;
            endcase
            if (e_step == 2) begin
                e_idx = (e_idx + 1) % 256;
                e_step = 0;
            end else begin
                e_step++;
            end
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] be,
                            input logic [7:0] v, input logic [23:0] low,
                            input string req);
        bit isc;
        int ci;
        @(negedge clk);
        chk(chg_valid == 1'b0, "R10 pulse length", {31'h0, chg_valid}, 32'h0);
        wr_valid = 1'b1;
        wr_addr = a;
        wr_be = be;
        wr_data = {v, low};
        @(negedge clk);
        wr_valid = 1'b0;
        model_write(a, be, v, isc, ci);
        chk(chg_valid == isc, req, {31'h0, chg_valid}, {31'h0, isc});
        chk(rd_data == 32'h0, "R8", rd_data, 32'h0);
        if (isc) begin
            chk(chg_index == ci[7:0], "R10 index", {24'h0, chg_index}, ci);
            pix_index = ci[7:0];
            #1;
            chk(pix_rgb == exp_mem[ci], req, {8'h0, pix_rgb}, {8'h0, exp_mem[ci]});
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [23:0] old_c;
        for (int i = 0; i < 256; i++) begin
            exp_mem[i] = (i == 255) ? 24'hFFFFFF : 24'h000000;
        end
        e_idx = 0;
        e_step = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents; R8: host read is zero
        chk(chg_valid == 1'b0, "R10 reset", {31'h0, chg_valid}, 32'h0);
        chk(rd_data == 32'h0, "R8", rd_data, 32'h0);
        sweep("R1 reset table");

        // R5: first component after reset goes to entry 0 red
        do_write(4'h4, 4'hF, 8'h5A, 24'hABCDEF, "R5 first write");

        // R3/R4: stream the whole table from index 0, wrapping at 255
        do_write(4'h0, 4'hF, 8'h00, 24'h123456, "R2 index load");
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                v = 8'((i * 37 + c * 91 + 5) & 255);
                do_write(4'h4, 4'hF, v, 24'h0, "R3 component order");
            end
        end
        // R4: index wrapped from 255 to 0
        do_write(4'h4, 4'hF, 8'hAA, 24'h0, "R4 wrap to entry 0");
        sweep("R3 full table");

        // R2: index reload mid-colour restarts at red
        do_write(4'h0, 4'hF, 8'd10, 24'h0, "R2 index load");
        do_write(4'h4, 4'hF, 8'h11, 24'h0, "R3 red");
        do_write(4'h0, 4'hF, 8'd20, 24'h0, "R2 mid-colour reload");
        do_write(4'h4, 4'hF, 8'h22, 24'h0, "R2 restart at red");

        // R6/R7: ignored writes, then the sequence continues unchanged
        do_write(4'h8, 4'hF, 8'h77, 24'h0, "R6 offset 8");
        do_write(4'hC, 4'hF, 8'h77, 24'h0, "R6 offset 12");
        do_write(4'h5, 4'hF, 8'h77, 24'h0, "R6 unaligned");
        do_write(4'h1, 4'hF, 8'h77, 24'h0, "R6 unaligned index");
        do_write(4'h0, 4'h7, 8'h99, 24'h0, "R7 partial index write");
        do_write(4'h4, 4'hE, 8'h66, 24'h0, "R7 partial data write");
        do_write(4'h4, 4'h0, 8'h66, 24'h0, "R7 no lanes");
        do_write(4'h4, 4'hF, 8'h33, 24'h0, "R6 green after ignored");
        do_write(4'h4, 4'hF, 8'h44, 24'h0, "R7 blue after ignored");
        do_write(4'h4, 4'hF, 8'h55, 24'h0, "R4 red of next entry");
        sweep("R6 table after ignored writes");

        // R9: same-cycle read of the entry being written sees the old value
        do_write(4'h0, 4'hF, 8'd255, 24'h0, "R2 index load");
        for (int c = 0; c < 3; c++) begin
            bit isc;
            int ci;
            v = 8'(8'h10 + c);
            @(negedge clk);
            pix_index = 8'd255;
            old_c = exp_mem[255];
            wr_valid = 1'b1;
            wr_addr = 4'h4;
            wr_be = 4'hF;
            wr_data = {v, 24'h0};
            #2;
            chk(pix_rgb == old_c, "R9 old value in write cycle", {8'h0, pix_rgb}, {8'h0, old_c});
            @(posedge clk);
            #1;
            model_write(4'h4, 4'hF, v, isc, ci);
            chk(pix_rgb == exp_mem[255], "R9 new value after edge", {8'h0, pix_rgb}, {8'h0, exp_mem[255]});
            @(negedge clk);
            wr_valid = 1'b0;
        end
        @(negedge clk);
        chk(e_idx == 0, "R4 index after 255", e_idx, 32'h0);
        do_write(4'h4, 4'hF, 8'hC3, 24'h0, "R4 255 wraps to 0");
        sweep("R9 final table");

        finish_run();
    end

endmodule